// File: doc/BRIEF.md
# I2C Bus Error Detection Register

This block sits beside an I2C interface and watches the two bus lines for protocol violations. A START condition is SDA falling while SCL is high. A STOP condition is SDA rising while SCL is high. Either one is legal between transfers. If one appears while the interface reports that a byte transfer is in progress, the block latches a sticky bus error flag. The flag forces the interface enable low, and that halts the interface and ends the transfer in progress.

Software sees an 8-bit control register and a companion clock-control register that holds the interface enable. Both are reached through a simple synchronous register port with a write strobe, a one-bit address, write data and combinational read data.

- The bus error flag is cleared by writing 0 to it. Writing 1 to it leaves it unchanged.
- An interrupt output is raised while both the flag and its enable bit are set.
- The remaining six control bits are plain read/write storage for the interface logic that sits around this block.

Top module: `i2c_buserr_ctrl`

## Requirements
- R1: After synchronous active-low reset, both registers read 0x00, `irq` is 0 and `if_enable` is 0.
- R2: The control register (address 0) has this layout: bit 7 is the bus error flag, bit 6 is the error interrupt enable, and bits 5..0 are plain storage (repeated-start control, master select, acknowledge enable, general-call acknowledge enable, transfer interrupt enable, transfer interrupt flag). Bits 6..0 read back the last value written to them.
- R3: A START (SDA 1 to 0 while SCL is 1) with `xfer_active` high sets the bus error flag. The raw lines pass through a two-flop synchroniser. If the input change is first sampled at clock edge n, the flag is 1 after edge n+2, provided `xfer_active` is high at that edge.
- R4: A STOP (SDA 0 to 1 while SCL is 1) under the same conditions sets the flag with the same timing.
- R5: The flag is not set in three cases: an SDA change while SCL is 0, a START or STOP seen while `xfer_active` is 0, and a write to the clock-control register.
- R6: Writing 0 to bit 7 of the control register clears the flag. Writing 1 to bit 7 leaves the flag unchanged.
- R7: If a bus error is detected at the same edge as a write that clears the flag, the flag stays 1.
- R8: The edge that sets the flag also drives `if_enable` to 0. `if_enable` stays 0 while the flag is 1.
- R9: Writes to the clock-control register (address 1, enable in bit 0, other bits read 0) cannot set `if_enable` while the flag is 1. Once the flag is clear, writing bit 0 sets or clears `if_enable`.
- R10: `irq` is 1 exactly while the flag and the error interrupt enable (bit 6) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 clock-control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sda_in | input | 1 | Raw SDA line, asynchronous |
| scl_in | input | 1 | Raw SCL line, asynchronous |
| xfer_active | input | 1 | High while a byte transfer is in progress |
| irq | output | 1 | Bus error interrupt |
| if_enable | output | 1 | Interface enable bit of the clock-control register |

## Verification
The detector is tried with four kinds of line activity:
- START and STOP with SCL high during a transfer. These show that both edge polarities are recognised.
- The same conditions while no transfer is active. These show that `xfer_active` gates the detection.
- SDA toggling while SCL is low during a transfer. This shows that only edges with SCL high count as conditions.
- A clearing write placed on the exact edge where a new error lands. This separates "error wins" from "last write wins".

Software traffic covers writes of 1 and of 0 to the flag, and enable writes made while the flag is set and after it is cleared. Together they show that the flag is sticky and that the enable is held off.

// File: rtl/i2c_buserr_pkg.sv
// Package: shared widths, bit positions and types for the I2C bus error block.
// Assumes an 8-bit register port; the field order is fixed by the struct below.
package i2c_buserr_pkg;

    localparam int REG_W      = 8;
    localparam int SYNC_DEPTH = 2;
    localparam int ENA_BIT    = 0;

    // Control register, most significant bit first.
    typedef struct packed {
        logic berr;       // sticky bus error flag
        logic berr_ie;    // bus error interrupt enable
        logic rstart;     // repeated-start control (storage)
        logic mstr;       // master select (storage)
        logic ack_en;     // acknowledge enable (storage)
        logic gca_en;     // general-call acknowledge enable (storage)
        logic xint_en;    // transfer interrupt enable (storage)
        logic xint_flag;  // transfer interrupt flag (storage)
    } ctrl_t;

    typedef enum logic [1:0] {
        COND_NONE  = 2'd0,
        COND_START = 2'd1,
        COND_STOP  = 2'd2
    } bus_cond_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-line flop-chain synchroniser.
// Each of LINES asynchronous inputs passes through STAGES flops.
// Assumes the idle level of every line is RST_VAL (an I2C bus idles high).
module i2c_line_sync #(
    parameter int   LINES   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw line through the chain, lowest index first.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL}};
            end else begin
                chain <= {chain[STAGES-2:0], async_in[ln]};
            end
        end

        assign sync_out[ln] = chain[LAST];
    end

endmodule

// File: rtl/i2c_cond_detect.sv
// Module: START/STOP condition detector.
// Compares the synchronised SDA with its value one cycle earlier while SCL is high.
// Assumes synchronised inputs whose reset level is the idle-high bus.
module i2c_cond_detect
    import i2c_buserr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sda_s,
    input  logic      scl_s,
    output bus_cond_e cond,
    output logic      cond_hit
);

    logic sda_prev;

    // Keep the previous synchronised SDA level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_prev <= 1'b1;
        end else begin
            sda_prev <= sda_s;
        end
    end

    // Classify the current cycle as START, STOP or nothing.
    always_comb begin
        cond = COND_NONE;
        if (scl_s && sda_prev && !sda_s) begin
            cond = COND_START;
        end else if (scl_s && !sda_prev && sda_s) begin
            cond = COND_STOP;
        end
    end

    assign cond_hit = (cond != COND_NONE);

endmodule

// File: rtl/i2c_ctrl_reg.sv
// Module: control register with sticky write-zero-to-clear bus error flag.
// A new error always wins over a clearing write in the same cycle.
// Assumes err_evt is already qualified by transfer activity.
module i2c_ctrl_reg
    import i2c_buserr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             err_evt,
    output ctrl_t            q
);

    ctrl_t wr_view;
    logic  berr_kept;

    assign wr_view = ctrl_t'(wdata);

    // Decide whether the flag survives this cycle's software access.
    always_comb begin
        berr_kept = q.berr;
        if (wr_en && !wr_view.berr) begin
            berr_kept = 1'b0;
        end
    end

    // Update storage bits on a write; set the flag on an error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (wr_en) begin
                q.berr_ie   <= wr_view.berr_ie;
                q.rstart    <= wr_view.rstart;
                q.mstr      <= wr_view.mstr;
                q.ack_en    <= wr_view.ack_en;
                q.gca_en    <= wr_view.gca_en;
                q.xint_en   <= wr_view.xint_en;
                q.xint_flag <= wr_view.xint_flag;
            end
            q.berr <= berr_kept | err_evt;
        end
    end

endmodule

// File: rtl/i2c_enable_reg.sv
// Module: interface enable bit of the clock-control register.
// A forced clear overrides any software write in the same cycle.
// Assumes force_clr is high for the whole time the error flag is set.
module i2c_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wbit,
    input  logic force_clr,
    output logic en
);

    // Hold, load or force the enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (force_clr) begin
            en <= 1'b0;
        end else if (wr_en) begin
            en <= wbit;
        end
    end

endmodule

// File: rtl/i2c_buserr_ctrl.sv
// Module: I2C bus error detection register, top level.
// Synchronises the bus lines, detects START/STOP during a transfer, and keeps
// the control register and the interface enable.
// Assumes xfer_active is synchronous to clk.
module i2c_buserr_ctrl
    import i2c_buserr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sda_in,
    input  logic             scl_in,
    input  logic             xfer_active,
    output logic             irq,
    output logic             if_enable
);

    localparam int SDA_IDX = 0;
    localparam int SCL_IDX = 1;

    logic [1:0] lines_s;
    bus_cond_e  cond;
    logic       cond_hit;
    logic       err_evt;
    logic       wr_ctrl;
    logic       wr_clk;
    ctrl_t      ctrl_q;

    i2c_line_sync #(
        .LINES   (2),
        .STAGES  (SYNC_DEPTH),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (lines_s)
    );

    i2c_cond_detect u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (lines_s[SDA_IDX]),
        .scl_s    (lines_s[SCL_IDX]),
        .cond     (cond),
        .cond_hit (cond_hit)
    );

    assign err_evt = cond_hit && xfer_active;
    assign wr_ctrl = reg_wr && !reg_addr;
    assign wr_clk  = reg_wr && reg_addr;

    i2c_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ctrl),
        .wdata   (reg_wdata),
        .err_evt (err_evt),
        .q       (ctrl_q)
    );

    i2c_enable_reg u_ena (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_clk),
        .wbit      (reg_wdata[ENA_BIT]),
        .force_clr (ctrl_q.berr || err_evt),
        .en        (if_enable)
    );

    // Return the selected register; unused clock-control bits read 0.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata[ENA_BIT] = if_enable;
        end else begin
            reg_rdata = ctrl_q;
        end
    end

    assign irq = ctrl_q.berr && ctrl_q.berr_ie;

endmodule

// File: rtl/i2c_buserr_chk.sv
// Module: assertion checker for i2c_buserr_ctrl, attached by bind.
// Assumes the port names of the top module and its internal ctrl_q/cond_hit.
module i2c_buserr_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_wr,
    input logic reg_addr,
    input logic wbit7,
    input logic xfer_active,
    input logic cond_hit,
    input logic berr,
    input logic irq,
    input logic if_enable
);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && !wbit7 && !(cond_hit && xfer_active)) |=> !berr);

    assert_write_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && wbit7 && !berr && !(cond_hit && xfer_active)) |=> !berr);

    assert_error_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_hit && xfer_active) |=> berr);

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!berr && !(cond_hit && xfer_active)) |=> !berr);

    assert_enable_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> !if_enable);

    assert_enable_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (berr && reg_wr && reg_addr) |=> !if_enable);

    assert_irq_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !if_enable);

endmodule

bind i2c_buserr_ctrl i2c_buserr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .wbit7       (reg_wdata[7]),
    .xfer_active (xfer_active),
    .cond_hit    (cond_hit),
    .berr        (ctrl_q.berr),
    .irq         (irq),
    .if_enable   (if_enable)
);

// File: tb/i2c_buserr_ctrl_test.sv
// Bench: behavioural reference model compared with the design on every clock.
module i2c_buserr_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sda_in = 1'b1;
    logic       scl_in = 1'b1;
    logic       xfer_active = 1'b0;
    logic       irq;
    logic       if_enable;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit [7:0] m_ctrl = 8'h00;
    bit       m_en = 1'b0;
    bit       sq[$];
    bit       cq[$];

    always #2 clk = ~clk;

    i2c_buserr_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .sda_in      (sda_in),
        .scl_in      (scl_in),
        .xfer_active (xfer_active),
        .irq         (irq),
        .if_enable   (if_enable)
    );

    // Model: each edge samples the lines; a condition seen two samples back counts.
    always @(posedge clk) begin
        bit evt;
        bit old_berr;
        if (!rst_n) begin
            m_ctrl = 8'h00;
            m_en   = 1'b0;
            sq     = '{1'b1, 1'b1, 1'b1};
            cq     = '{1'b1, 1'b1, 1'b1};
        end else begin
            evt      = xfer_active && cq[1] && (sq[0] != sq[1]);
            old_berr = m_ctrl[7];
            if (reg_wr && !reg_addr) begin
                m_ctrl[6:0] = reg_wdata[6:0];
                m_ctrl[7]   = (old_berr && reg_wdata[7]) || evt;
            end else begin
                m_ctrl[7] = old_berr || evt;
            end
            if (old_berr || evt) m_en = 1'b0;
            else if (reg_wr && reg_addr) m_en = reg_wdata[0];
            sq.push_back(sda_in);
            void'(sq.pop_front());
            cq.push_back(scl_in);
            void'(cq.pop_front());
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] exp_rd;
            exp_rd = reg_addr ? {7'b0, m_en} : m_ctrl;
            checks++;
            if (reg_rdata !== exp_rd || irq !== (m_ctrl[7] && m_ctrl[6]) || if_enable !== m_en) begin
                errors++;
                $display("FAIL %s t=%0t rdata=%h irq=%b en=%b expected rdata=%h irq=%b en=%b",
                         cur_req, $time, reg_rdata, irq, if_enable,
                         exp_rd, m_ctrl[7] && m_ctrl[6], m_en);
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_reg(input bit a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            summary();
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        step(5);
        rst_n = 1'b1;
        step(3);
        reg_addr = 1'b1; step(2); reg_addr = 1'b0;

        cur_req = "R2";
        write_reg(1'b0, 8'h2A);
        step(2);
        write_reg(1'b0, 8'h15);
        step(2);
        write_reg(1'b1, 8'h01);
        reg_addr = 1'b1; step(2); reg_addr = 1'b0;

        cur_req = "R3";
        xfer_active = 1'b1; scl_in = 1'b1;
        sda_in = 1'b0;
        step(5);
        reg_addr = 1'b1; step(2); reg_addr = 1'b0;

        cur_req = "R10";
        write_reg(1'b0, 8'h80);
        step(2);
        write_reg(1'b0, 8'hC0);
        step(3);

        cur_req = "R9";
        write_reg(1'b1, 8'h01);
        reg_addr = 1'b1; step(2); reg_addr = 1'b0;

        cur_req = "R6";
        write_reg(1'b0, 8'hC0);
        step(2);
        write_reg(1'b0, 8'h40);
        step(3);

        cur_req = "R9";
        write_reg(1'b1, 8'h01);
        reg_addr = 1'b1; step(2);
        write_reg(1'b1, 8'h00);
        reg_addr = 1'b1; step(2);
        write_reg(1'b1, 8'h01);
        reg_addr = 1'b0; step(2);

        cur_req = "R5";
        xfer_active = 1'b0;
        sda_in = 1'b1; step(4);
        sda_in = 1'b0; step(4);
        xfer_active = 1'b1;
        scl_in = 1'b0; step(3);
        sda_in = 1'b1; step(4);
        sda_in = 1'b0; step(4);
        sda_in = 1'b1; step(4);
        write_reg(1'b1, 8'h01);
        step(3);

        cur_req = "R4";
        sda_in = 1'b0; step(3);
        scl_in = 1'b1; step(3);
        sda_in = 1'b1;
        step(5);
        reg_addr = 1'b1; step(2); reg_addr = 1'b0;

        cur_req = "R7";
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'h01);
        step(2);
        sda_in = 1'b0;
        step(2);
        write_reg(1'b0, 8'h40);
        step(4);

        cur_req = "R8";
        write_reg(1'b1, 8'h01);
        reg_addr = 1'b1; step(3); reg_addr = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule